// File: doc/BRIEF.md
# Bit-serial control word serializer

This block sends a parallel control word to a remote control latch over three wires: a data line, a shift clock and a latch strobe. A host presents a word on a valid/ready handshake. Once the word is accepted, the engine drives all three wires low for one phase. It then clocks the word out bit by bit, starting with the least significant bit. Each bit takes three phases: data setup with the clock low, clock high, and clock low again, with the data held throughout. At the end it raises the strobe for one phase so the remote latch takes the new word. Then it returns to idle and raises a one-cycle completion pulse.

The duration of every wire phase is a number of system clocks. The host sets this number with a prescaler input, which is captured at the moment the request is accepted. A request made while a word is in flight is not dropped: it stays pending until the engine is idle again. A synchronous reset abandons any word in flight and parks the wires low.

Top module: `ctlser_top`

## Requirements
- R1: While idle, `req_ready` is 1 and `ser_data`, `ser_clk` and `ser_strobe` are all 0. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both 1.
- R2: Starting with the cycle after acceptance, all three wires stay 0 for one full phase before the first bit appears.
- R3: Exactly WORD_W bits (default 20) are sent per word, least significant first: bit 0 of `req_word` is the first bit on `ser_data`.
- R4: Each bit takes three phases in this order: `ser_data`=bit with `ser_clk`=0, then `ser_clk`=1, then `ser_clk`=0. `ser_data` does not change across the three phases and `ser_strobe` is 0.
- R5: After the last bit, `ser_strobe` is 1 for one phase while `ser_data` and `ser_clk` are 0. After that phase all three wires return to 0.
- R6: One phase lasts P system clocks, where P is the value of `prescale` at acceptance; a value of 0 is treated as 1. A word therefore keeps `req_ready` low for exactly 62*P cycles at the default width. A change of `prescale` after acceptance has no effect on that word.
- R7: `req_ready` is 0 from the cycle after acceptance until the wires are back to idle after the strobe. A request held while busy is accepted at the first edge where `req_ready` is 1, and the word and prescale present at that edge are used.
- R8: `done` is 1 for exactly one cycle: the first idle cycle after the strobe phase. In that cycle `req_ready` is also 1, and a new request may be accepted in it.
- R9: A synchronous reset (`rst`=1 at a clock edge) drives all three wires to 0, `done` to 0 and `req_ready` to 1 from the next cycle, abandoning any word in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host has a word to send |
| req_word | input | WORD_W | Control word to serialize |
| prescale | input | PRE_W | System clocks per wire phase (0 treated as 1) |
| req_ready | output | 1 | Engine idle and able to accept a word |
| ser_data | output | 1 | Serial data wire |
| ser_clk | output | 1 | Shift clock wire |
| ser_strobe | output | 1 | Latch strobe wire |
| done | output | 1 | One-cycle pulse when the wires return to idle |

## Verification
The bench uses the default parameters: WORD_W=20, so the whole 20-bit shift, including the last-bit-to-strobe transition, is visible in each word, and PRE_W=8. With PRE_W=8 the prescale can be stepped through 0, 1, 2 and 3 to exercise the zero-as-one rule, the single-cycle phase and multi-cycle phases. The prescaler is also changed to a large value while a word is in flight, to show that the captured value governs that word. Back-to-back requests, including one accepted in the done cycle, and a reset in the middle of a word are checked against a cycle-by-cycle reference model.

// File: rtl/ctlser_pkg.sv
package ctlser_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_LEAD   = 3'd1,
        PH_SETUP  = 3'd2,
        PH_RISE   = 3'd3,
        PH_FALL   = 3'd4,
        PH_STROBE = 3'd5
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   data;
        logic   sclk;
        logic   strobe;
        logic   done;
    } seq_state_t;

endpackage

// File: rtl/ctlser_timer.sv
module ctlser_timer #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [PRE_W-1:0] limit_in,
    input  logic             run,
    output logic             tick
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
        logic [PRE_W-1:0] lim;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign tick = run && (tmr_q.cnt == tmr_q.lim - PRE_W'(1));

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.cnt = '0;
            tmr_d.lim = (limit_in == '0) ? PRE_W'(1) : limit_in;
        end else if (run) begin
            if (tick) tmr_d.cnt = '0;
            else      tmr_d.cnt = tmr_q.cnt + PRE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q.cnt <= '0;
            tmr_q.lim <= PRE_W'(1);
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // R6: the phase counter never passes the captured phase length
    assert_cnt_in_phase_R6: assert property (@(posedge clk) disable iff (rst)
        (tmr_q.lim != '0) && (tmr_q.cnt < tmr_q.lim))
        else $error("phase counter out of range");

endmodule

// File: rtl/ctlser_shreg.sv
module ctlser_shreg #(
    parameter int WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic              shift,
    output logic              cur_bit,
    output logic              next_bit,
    output logic              last
);
    localparam int LW = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [LW-1:0]     left;
    } sr_t;

    sr_t sr_d, sr_q;

    assign cur_bit  = sr_q.sh[0];
    assign next_bit = sr_q.sh[1];
    assign last     = (sr_q.left == LW'(1));

    always_comb begin
        sr_d = sr_q;
        if (load) begin
            sr_d.sh   = word_in;
            sr_d.left = LW'(WORD_W);
        end else if (shift) begin
            sr_d.sh   = sr_q.sh >> 1;
            sr_d.left = (sr_q.left == '0) ? '0 : sr_q.left - LW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= sr_d;
    end

    // R3: never more bits pending than a word holds
    assert_left_bound_R3: assert property (@(posedge clk) disable iff (rst)
        sr_q.left <= LW'(WORD_W))
        else $error("bit count above word width");

    // R3: a load always restarts the bit count at the full word
    assert_load_count_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> (sr_q.left == LW'(WORD_W)))
        else $error("bit count not restarted on load");

endmodule

// File: rtl/ctlser_seq.sv
module ctlser_seq
    import ctlser_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic tick,
    input  logic cur_bit,
    input  logic next_bit,
    input  logic last,
    output logic ready,
    output logic accept,
    output logic shift,
    output logic run,
    output logic data,
    output logic sclk,
    output logic strobe,
    output logic done
);
    seq_state_t st_d, st_q;

    assign ready  = (st_q.phase == PH_IDLE);
    assign accept = ready && req_valid;
    assign run    = !ready;
    assign shift  = (st_q.phase == PH_FALL) && tick;

    assign data   = st_q.data;
    assign sclk   = st_q.sclk;
    assign strobe = st_q.strobe;
    assign done   = st_q.done;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) st_d.phase = PH_LEAD;
            end
            PH_LEAD: begin
                if (tick) begin
                    st_d.phase = PH_SETUP;
                    st_d.data  = cur_bit;
                end
            end
            PH_SETUP: begin
                if (tick) begin
                    st_d.phase = PH_RISE;
                    st_d.sclk  = 1'b1;
                end
            end
            PH_RISE: begin
                if (tick) begin
                    st_d.phase = PH_FALL;
                    st_d.sclk  = 1'b0;
                end
            end
            PH_FALL: begin
                if (tick) begin
                    if (last) begin
                        st_d.phase  = PH_STROBE;
                        st_d.data   = 1'b0;
                        st_d.strobe = 1'b1;
                    end else begin
                        st_d.phase = PH_SETUP;
                        st_d.data  = next_bit;
                    end
                end
            end
            PH_STROBE: begin
                if (tick) begin
                    st_d.phase  = PH_IDLE;
                    st_d.strobe = 1'b0;
                    st_d.done   = 1'b1;
                end
            end
            default: begin
                st_d = '{phase: PH_IDLE, data: 1'b0, sclk: 1'b0,
                         strobe: 1'b0, done: 1'b0};
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{phase: PH_IDLE, data: 1'b0, sclk: 1'b0,
                      strobe: 1'b0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // R1: idle keeps every wire low
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        ready |-> (!data && !sclk && !strobe))
        else $error("wire active while idle");

    // R5: strobe only with data and clock low
    assert_strobe_alone_R5: assert property (@(posedge clk) disable iff (rst)
        strobe |-> (!data && !sclk))
        else $error("strobe overlaps data or clock");

    // R4: data held across the clock rising
    assert_rise_hold_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> $stable(data))
        else $error("data moved with clock rise");

    // R4: data held across the clock falling
    assert_fall_hold_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> $stable(data))
        else $error("data moved with clock fall");

    // R8: completion pulse lasts one cycle and coincides with ready
    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done)
        else $error("done longer than one cycle");

    assert_done_ready_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> ready)
        else $error("done without ready");

    // R7: an accepted request drops ready on the next cycle
    assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ready)
        else $error("ready still high after accept");

endmodule

// File: rtl/ctlser_top.sv
module ctlser_top #(
    parameter int WORD_W = 20,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] req_word,
    input  logic [PRE_W-1:0]  prescale,
    output logic              req_ready,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              ser_strobe,
    output logic              done
);
    logic accept, shift, run, tick;
    logic cur_bit, next_bit, last;

    ctlser_timer #(.PRE_W(PRE_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .limit_in (prescale),
        .run      (run),
        .tick     (tick)
    );

    ctlser_shreg #(.WORD_W(WORD_W)) u_shreg (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .word_in  (req_word),
        .shift    (shift),
        .cur_bit  (cur_bit),
        .next_bit (next_bit),
        .last     (last)
    );

    ctlser_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .tick      (tick),
        .cur_bit   (cur_bit),
        .next_bit  (next_bit),
        .last      (last),
        .ready     (req_ready),
        .accept    (accept),
        .shift     (shift),
        .run       (run),
        .data      (ser_data),
        .sclk      (ser_clk),
        .strobe    (ser_strobe),
        .done      (done)
    );

    // R9: reset parks the wires and reopens the handshake
    assert_reset_idle_R9: assert property (@(posedge clk)
        rst |=> (!ser_data && !ser_clk && !ser_strobe && req_ready && !done))
        else $error("reset did not return to idle");

endmodule

// File: tb/ctlser_top_test.sv
`timescale 1ns/1ps
module ctlser_top_test;
    localparam int WORD_W = 20;
    localparam int PRE_W  = 8;
    localparam logic [4:0] IDLE_V = 5'b10000; // {ready,done,data,clk,strobe}

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [WORD_W-1:0] req_word = '0;
    logic [PRE_W-1:0]  prescale = PRE_W'(1);
    logic              req_ready, ser_data, ser_clk, ser_strobe, done;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ctlser_top #(.WORD_W(WORD_W), .PRE_W(PRE_W)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_word(req_word),
        .prescale(prescale), .req_ready(req_ready), .ser_data(ser_data),
        .ser_clk(ser_clk), .ser_strobe(ser_strobe), .done(done)
    );

    // ---------------- reference model ----------------
    logic [4:0] exp_q[$];
    logic [4:0] cur = IDLE_V;
    bit armed = 0;

    task automatic push_n(input logic [4:0] v, input int n);
        for (int k = 0; k < n; k++) exp_q.push_back(v);
    endtask

    task automatic build(input logic [WORD_W-1:0] w, input int p);
        push_n(5'b00000, p);                       // lead-in, all low
        for (int b = 0; b < WORD_W; b++) begin     // LSB first
            push_n({2'b00, w[b], 2'b00}, p);
            push_n({2'b00, w[b], 2'b10}, p);
            push_n({2'b00, w[b], 2'b00}, p);
        end
        push_n(5'b00001, p);                       // strobe
        exp_q.push_back(5'b11000);                 // done with ready
    endtask

    always @(posedge clk) begin
        if (rst) begin
            exp_q.delete();
            cur   = IDLE_V;
            armed = 1;
        end else if (armed) begin
            if (cur[4] && req_valid)
                build(req_word, (prescale == 0) ? 1 : int'(prescale));
            cur = (exp_q.size() > 0) ? exp_q.pop_front() : IDLE_V;
        end
    end

    always @(negedge clk) begin
        if (armed && !finished) begin
            logic [4:0] act;
            act = {req_ready, done, ser_data, ser_clk, ser_strobe};
            total++;
            if (act !== cur) begin
                bad++;
                if (act[4] !== cur[4])
                    $display("FAIL R1/R7 ready @%0t actual=%b expected=%b", $time, act, cur);
                else if (act[3] !== cur[3])
                    $display("FAIL R8 done @%0t actual=%b expected=%b", $time, act, cur);
                else if (act[0] !== cur[0])
                    $display("FAIL R5 strobe @%0t actual=%b expected=%b", $time, act, cur);
                else if (act[1] !== cur[1])
                    $display("FAIL R4 clock @%0t actual=%b expected=%b", $time, act, cur);
                else
                    $display("FAIL R2/R3 data @%0t actual=%b expected=%b", $time, act, cur);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // present a request at a negedge and hold it until accepted
    task automatic send(input logic [WORD_W-1:0] w, input logic [PRE_W-1:0] p);
        bit ok;
        req_valid = 1'b1;
        req_word  = w;
        prescale  = p;
        forever begin
            ok = req_ready;
            @(negedge clk);
            if (ok) break;
        end
        req_valid = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (!req_ready) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 / R1: reset state
        chk(req_ready === 1'b1, "R9 ready after reset", int'(req_ready), 1);
        chk({ser_data, ser_clk, ser_strobe, done} === 4'b0, "R1 wires low after reset",
            int'({ser_data, ser_clk, ser_strobe, done}), 0);
        repeat (2) @(negedge clk);

        // R3/R4: single-clock phases
        send(20'hA53C6, 8'd1);
        wait_idle(n);
        chk(n == 62, "R6 busy length P=1", n, 62);
        chk(done === 1'b1, "R8 done on return to idle", int'(done), 1);
        @(negedge clk);
        chk(done === 1'b0, "R8 done one cycle", int'(done), 0);

        // R6: P=3, prescale changed mid-word; R7: pending request held off
        send(20'hFFFFF, 8'd3);
        prescale = 8'd9;
        repeat (10) @(negedge clk);
        send(20'h00001, 8'd2);               // held until ready returns
        wait_idle(n);
        chk(n == 124, "R7 held request busy length P=2", n, 124);

        // R6: prescale 0 behaves as 1
        send(20'h50F0A, 8'd0);
        wait_idle(n);
        chk(n == 62, "R6 prescale zero as one", n, 62);

        // R8: back-to-back, second accepted in the done cycle
        send(20'h80000, 8'd1);
        send(20'h7FFFE, 8'd2);
        wait_idle(n);
        chk(n == 124, "R8 accept in done cycle", n, 124);

        // R9: reset in the middle of a word
        send(20'h3C3C3, 8'd2);
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk({req_ready, ser_data, ser_clk, ser_strobe, done} === 5'b10000,
            "R9 mid-word reset", int'({req_ready, ser_data, ser_clk, ser_strobe, done}), 16);
        repeat (5) @(negedge clk);
        chk(done === 1'b0, "R9 no done after abandoned word", int'(done), 0);

        // R2/R3/R5 once more after reset, P=3
        send(20'h0F00F, 8'd3);
        wait_idle(n);
        chk(n == 186, "R6 busy length P=3", n, 186);
        repeat (4) @(negedge clk);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule